// File: doc/BRIEF.md
# Redundant Boot Header Selector

After reset this block walks a small table of boot headers held in a word-addressed store. It finds the first one that can be trusted and turns it into the start-up decision for the chip. There are four header sets, and each set has an original and a duplicate, which gives eight entries. The block takes them in the order original 0, duplicate 0, original 1, duplicate 1, and so on. It reads the four words of one entry on four consecutive clocks, then judges that entry.

An entry is trusted when its tag matches a fixed value, when its check word is the bitwise complement of its complement word, and when its mode field holds a defined code. The trusted entry supplies the start-up mode, the start address and the per-core lockstep, self-test and checker-software enables. Two configuration straps can replace the mode, but only when the header allows it. A start address that is misaligned or lies outside program flash turns the result into an error. So does a table with no trusted entry. In both cases the block falls back to the generic loader mode. The result is held until the next reset.

Top module: `boot_hdr_sel`

## Requirements
- R1: While reset is active and in the first cycle after release, `done`, `error`, `rd_en`, `start_addr`, `lockstep_en`, `selftest_en` and `checker_en` are 0, and `boot_mode` holds the generic loader code 3.
- R2: Entry e (0..7) is original set e/2 when e is even and its duplicate when e is odd. Its word w (0..3) is read at address `HDR_BASE + 4*e + w`. Entries are examined in rising order of e. The four reads of entry k are issued 7k+1 to 7k+4 clock edges after the first edge with reset released. When n entries are examined, `done` rises on edge 7n.
- R3: An entry is valid only if word 0 bits [31:16] equal 0xB359 and word 2 equals the bitwise inverse of word 3. Otherwise the scan moves on to the next entry.
- R4: The mode field is the index word (word 0 bits [15:0]) bits [3:1]. Code 111 gives output 0 (flash start), 110 gives output 1 (alternate boot, generic loader fallback), 100 gives output 3 (generic loader) and 011 gives output 4 (serial loader). Any other code makes the entry invalid.
- R5: The index bits [7:4] drive `lockstep_en[3:0]` and bit 8 drives `selftest_en`. `checker_en` is 0 exactly when bits [11:9] equal 101. Bits [15:12] have no effect.
- R6: When index bit 0 is 0 and `strap_en_n` is 0, `strap_mode` picks the mode: 11 gives 0, 10 gives 1, 01 gives 2 (alternate boot, serial loader fallback) and 00 gives 3. In every other case the header mode is used.
- R7: For modes 0, 1 and 2, `start_addr` is word 1. Word 1 must have bits [1:0] equal to 0 and must lie within `PF_LO`..`PF_HI` inclusive. If it does not, `error` is 1, `boot_mode` is 3 and `start_addr` is 0, while the enables still come from the header. For modes 3 and 4, `start_addr` is 0 and word 1 is not checked.
- R8: If none of the eight entries is valid, `done` and `error` are 1 after edge 56, `boot_mode` is 3, and `start_addr` and all enables are 0.
- R9: Once `done` is 1, all outputs keep their values, no further reads are issued, and later strap changes have no effect until reset.
- R10: The first valid entry decides the result. Later valid entries are never read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | output | 1 | Read strobe to the header store |
| rd_addr | output | ADDR_W | Word address of the read |
| rd_data | input | 32 | Read data, valid the cycle after the strobe |
| strap_en_n | input | 1 | Strap selection request, active low |
| strap_mode | input | 2 | Strap mode pins |
| done | output | 1 | Result is final |
| error | output | 1 | No usable header or bad start address |
| boot_mode | output | 3 | Selected start-up mode code |
| start_addr | output | 32 | Start address, 0 when unused |
| lockstep_en | output | NCORE | Per-core lockstep enables |
| selftest_en | output | 1 | Logic self-test enable |
| checker_en | output | 1 | Checker software enable |

## Verification
Some properties are checked on every cycle. These are the read burst shape (four consecutive word addresses starting on an entry boundary, then a gap), silence on the read port once done, the frozen result, the fallback values paired with `error`, and that a start address without error is aligned and inside flash. Other behaviour can only be shown by the bench's scenarios, because it needs the header contents: which entry wins, the tag and complement-pair tests, rejection of undefined codes, strap priority against the header's permission bit, the enable field decoding, and the exact completion edge for 1, 2, 3 and 8 examined entries.

// File: rtl/bhs_pkg.sv
package bhs_pkg;

   localparam int unsigned HDR_WORDS = 4;
   localparam logic [15:0] HDR_TAG   = 16'hB359;
   localparam logic [2:0]  CS_OFF    = 3'b101;

   typedef enum logic [2:0] {
      BM_FLASH   = 3'd0,
      BM_ALT_GEN = 3'd1,
      BM_ALT_SER = 3'd2,
      BM_GEN_BSL = 3'd3,
      BM_SER_BSL = 3'd4
   } boot_mode_e;

   typedef struct packed {
      logic [15:0] tag;
      logic [15:0] idx;
      logic [31:0] stad;
      logic [31:0] chk;
      logic [31:0] chk_n;
   } hdr_raw_t;

   typedef struct packed {
      logic       ok;
      logic       pin_dis;
      boot_mode_e mode;
      logic [3:0] ls;
      logic       st;
      logic       cs;
   } hdr_dec_t;

   function automatic logic uses_addr(boot_mode_e m);
      return (m == BM_FLASH) || (m == BM_ALT_GEN) || (m == BM_ALT_SER);
   endfunction

endpackage

// File: rtl/bhs_fetch.sv
module bhs_fetch
   import bhs_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned HDR_BASE = 0,
   parameter int unsigned ENT_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ENT_W-1:0]  entry,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [31:0]       rd_data,
   output hdr_raw_t          hdr,
   output logic              hdr_vld
);

   logic       busy_q;
   logic [1:0] cnt_q;
   logic       cap_q;
   logic [1:0] cap_idx_q;
   logic       vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cnt_q     <= 2'd0;
         cap_q     <= 1'b0;
         cap_idx_q <= 2'd0;
         vld_q     <= 1'b0;
      end else begin
         cap_q     <= busy_q;
         cap_idx_q <= cnt_q;
         vld_q     <= cap_q && (cap_idx_q == 2'd3);
         if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= 2'd0;
         end else if (busy_q) begin
            cnt_q <= cnt_q + 2'd1;
            if (cnt_q == 2'd3) busy_q <= 1'b0;
         end
      end
   end

   generate
      for (genvar gi = 0; gi < HDR_WORDS; gi++) begin : g_word
         logic [31:0] w_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            w_q <= '0;
            else if (cap_q && cap_idx_q == 2'(gi)) w_q <= rd_data;
         end
      end
   endgenerate

   assign rd_en   = busy_q;
   assign rd_addr = ADDR_W'(HDR_BASE) + ADDR_W'({entry, cnt_q});
   assign hdr_vld = vld_q;

   always_comb begin
      hdr.tag   = g_word[0].w_q[31:16];
      hdr.idx   = g_word[0].w_q[15:0];
      hdr.stad  = g_word[1].w_q;
      hdr.chk   = g_word[2].w_q;
      hdr.chk_n = g_word[3].w_q;
   end

endmodule

// File: rtl/bhs_check.sv
module bhs_check
   import bhs_pkg::*;
(
   input  hdr_raw_t hdr,
   output hdr_dec_t dec
);

   logic code_ok;
   logic unused_idx_bits;

   assign unused_idx_bits = ^hdr.idx;

   always_comb begin
      code_ok  = 1'b1;
      dec.mode = BM_GEN_BSL;
      unique case (hdr.idx[3:1])
         3'b111:  dec.mode = BM_FLASH;
         3'b110:  dec.mode = BM_ALT_GEN;
         3'b100:  dec.mode = BM_GEN_BSL;
         3'b011:  dec.mode = BM_SER_BSL;
         default: code_ok  = 1'b0;
      endcase
      dec.ok      = (hdr.tag == HDR_TAG) && (hdr.chk == ~hdr.chk_n) && code_ok;
      dec.pin_dis = hdr.idx[0];
      dec.ls      = hdr.idx[7:4];
      dec.st      = hdr.idx[8];
      dec.cs      = (hdr.idx[11:9] != CS_OFF);
   end

endmodule

// File: rtl/bhs_resolve.sv
module bhs_resolve
   import bhs_pkg::*;
#(
   parameter logic [31:0] PF_LO       = 32'hA000_0000,
   parameter logic [31:0] PF_HI       = 32'hA03F_FFFC,
   parameter bit          CHECK_RANGE = 1'b1
) (
   input  hdr_dec_t    dec,
   input  logic [31:0] stad,
   input  logic        strap_en_n,
   input  logic [1:0]  strap_mode,
   output boot_mode_e  mode,
   output logic        addr_fault
);

   logic in_range;
   logic aligned;

   generate
      if (CHECK_RANGE) begin : g_range
         assign in_range = (stad >= PF_LO) && (stad <= PF_HI);
      end else begin : g_norange
         assign in_range = 1'b1;
      end
   endgenerate

   assign aligned = (stad[1:0] == 2'b00);

   always_comb begin
      mode = dec.mode;
      if (!dec.pin_dis && !strap_en_n) begin
         unique case (strap_mode)
            2'b11: mode = BM_FLASH;
            2'b10: mode = BM_ALT_GEN;
            2'b01: mode = BM_ALT_SER;
            2'b00: mode = BM_GEN_BSL;
         endcase
      end
   end

   assign addr_fault = uses_addr(mode) && !(aligned && in_range);

endmodule

// File: rtl/boot_hdr_sel.sv
module boot_hdr_sel
   import bhs_pkg::*;
#(
   parameter int unsigned NUM_SETS    = 4,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned HDR_BASE    = 0,
   parameter int unsigned NCORE       = 4,
   parameter logic [31:0] PF_LO       = 32'hA000_0000,
   parameter logic [31:0] PF_HI       = 32'hA03F_FFFC,
   parameter bit          CHECK_RANGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [31:0]       rd_data,
   input  logic              strap_en_n,
   input  logic [1:0]        strap_mode,
   output logic              done,
   output logic              error,
   output logic [2:0]        boot_mode,
   output logic [31:0]       start_addr,
   output logic [NCORE-1:0]  lockstep_en,
   output logic              selftest_en,
   output logic              checker_en
);

   localparam int unsigned NUM_ENT = 2 * NUM_SETS;
   localparam int unsigned ENT_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
   localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(NUM_ENT - 1);

   generate
      if (NCORE < 1 || NCORE > 4) begin : g_bad_ncore
         $error("NCORE must be 1..4");
      end
      if (NUM_SETS < 1) begin : g_bad_sets
         $error("NUM_SETS must be at least 1");
      end
      if (ADDR_W < ENT_W + 2) begin : g_bad_aw
         $error("ADDR_W too small for the header table");
      end
      if ((HDR_BASE % 4) != 0) begin : g_bad_base
         $error("HDR_BASE must be a multiple of 4");
      end
      if (PF_LO > PF_HI) begin : g_bad_range
         $error("PF_LO must not exceed PF_HI");
      end
   endgenerate

   typedef enum logic [1:0] {ST_LAUNCH, ST_WAIT, ST_END} state_e;

   state_e            st_q;
   logic [ENT_W-1:0]  ent_q;
   hdr_raw_t          hdr;
   logic              hdr_vld;
   hdr_dec_t          dec;
   boot_mode_e        fin_mode;
   logic              addr_fault;

   logic              done_q, err_q, st_en_q, cs_q;
   boot_mode_e        mode_q;
   logic [31:0]       addr_q;
   logic [NCORE-1:0]  ls_q;

   bhs_fetch #(
      .ADDR_W   (ADDR_W),
      .HDR_BASE (HDR_BASE),
      .ENT_W    (ENT_W)
   ) u_fetch (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (st_q == ST_LAUNCH),
      .entry   (ent_q),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .hdr     (hdr),
      .hdr_vld (hdr_vld)
   );

   bhs_check u_check (
      .hdr (hdr),
      .dec (dec)
   );

   bhs_resolve #(
      .PF_LO       (PF_LO),
      .PF_HI       (PF_HI),
      .CHECK_RANGE (CHECK_RANGE)
   ) u_resolve (
      .dec        (dec),
      .stad       (hdr.stad),
      .strap_en_n (strap_en_n),
      .strap_mode (strap_mode),
      .mode       (fin_mode),
      .addr_fault (addr_fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_LAUNCH;
         ent_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         mode_q  <= BM_GEN_BSL;
         addr_q  <= '0;
         ls_q    <= '0;
         st_en_q <= 1'b0;
         cs_q    <= 1'b0;
      end else begin
         unique case (st_q)
            ST_LAUNCH: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (hdr_vld) begin
                  if (dec.ok) begin
                     st_q    <= ST_END;
                     done_q  <= 1'b1;
                     ls_q    <= dec.ls[NCORE-1:0];
                     st_en_q <= dec.st;
                     cs_q    <= dec.cs;
                     if (addr_fault) begin
                        err_q  <= 1'b1;
                        mode_q <= BM_GEN_BSL;
                        addr_q <= '0;
                     end else begin
                        mode_q <= fin_mode;
                        addr_q <= uses_addr(fin_mode) ? hdr.stad : 32'd0;
                     end
                  end else if (ent_q == LAST_ENT) begin
                     st_q   <= ST_END;
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                     mode_q <= BM_GEN_BSL;
                     addr_q <= '0;
                  end else begin
                     ent_q <= ent_q + 1'b1;
                     st_q  <= ST_LAUNCH;
                  end
               end
            end
            default: st_q <= ST_END;
         endcase
      end
   end

   assign done        = done_q;
   assign error       = err_q;
   assign boot_mode   = mode_q;
   assign start_addr  = addr_q;
   assign lockstep_en = ls_q;
   assign selftest_en = st_en_q;
   assign checker_en  = cs_q;

endmodule

// File: rtl/boot_hdr_sel_chk.sv
module boot_hdr_sel_chk #(
   parameter int unsigned ADDR_W      = 8,
   parameter logic [31:0] PF_LO       = 32'hA000_0000,
   parameter logic [31:0] PF_HI       = 32'hA03F_FFFC,
   parameter bit          CHECK_RANGE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              done,
   input logic              error,
   input logic [2:0]        boot_mode,
   input logic [31:0]       start_addr
);

   a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done && $stable(error) && $stable(boot_mode) && $stable(start_addr));

   a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rd_en);

   a_r2_word_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr[1:0] != 2'd3) |=> (rd_en && rd_addr == $past(rd_addr) + ADDR_W'(1)));

   a_r2_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr[1:0] == 2'd3) |=> !rd_en);

   a_r2_burst_begin: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_en) |-> (rd_addr[1:0] == 2'd0));

   a_r7_fault_fallback: assert property (@(posedge clk) disable iff (!rst_n)
      (done && error) |-> (boot_mode == 3'd3 && start_addr == 32'd0));

   a_r7_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !error && boot_mode <= 3'd2) |->
         (start_addr[1:0] == 2'b00 &&
          (!CHECK_RANGE || (start_addr >= PF_LO && start_addr <= PF_HI))));

   a_r7_loader_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (boot_mode == 3'd3 || boot_mode == 3'd4)) |-> (start_addr == 32'd0));

   a_r4_mode_code: assert property (@(posedge clk) disable iff (!rst_n)
      boot_mode <= 3'd4);

endmodule

bind boot_hdr_sel boot_hdr_sel_chk #(
   .ADDR_W      (ADDR_W),
   .PF_LO       (PF_LO),
   .PF_HI       (PF_HI),
   .CHECK_RANGE (CHECK_RANGE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .done       (done),
   .error      (error),
   .boot_mode  (boot_mode),
   .start_addr (start_addr)
);

// File: tb/boot_hdr_sel_tb_top.sv
`timescale 1ns/1ps
module boot_hdr_sel_tb_top;

   localparam logic [31:0] LO = 32'hA000_0000;
   localparam logic [31:0] HI = 32'hA03F_FFFC;
   localparam logic [31:0] GA = 32'hA000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en;
   logic [7:0]  rd_addr;
   logic [31:0] rd_data = '0;
   logic        strap_en_n = 1'b1;
   logic [1:0]  strap_mode = 2'b00;
   logic        done, error, selftest_en, checker_en;
   logic [2:0]  boot_mode;
   logic [31:0] start_addr;
   logic [3:0]  lockstep_en;

   logic [31:0] mem [0:31];

   int n_chk = 0;
   int n_fail = 0;
   bit flip_straps = 1'b0;

   int          e_n;
   logic [2:0]  e_mode;
   logic [31:0] e_addr;
   logic        e_err, e_st, e_cs;
   logic [3:0]  e_ls;

   always #5 clk = ~clk;

   boot_hdr_sel #(
      .NUM_SETS (4), .ADDR_W (8), .HDR_BASE (0), .NCORE (4),
      .PF_LO (LO), .PF_HI (HI), .CHECK_RANGE (1'b1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .rd_en (rd_en), .rd_addr (rd_addr),
      .rd_data (rd_data), .strap_en_n (strap_en_n), .strap_mode (strap_mode),
      .done (done), .error (error), .boot_mode (boot_mode),
      .start_addr (start_addr), .lockstep_en (lockstep_en),
      .selftest_en (selftest_en), .checker_en (checker_en)
   );

   // header store model: data one cycle after the strobe
   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[4:0]];

   task automatic check(input bit ok, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   function automatic logic [15:0] mk_idx(bit pd, logic [2:0] code, logic [3:0] ls,
                                          bit st, logic [2:0] cs);
      return {4'h0, cs, st, ls, code, pd};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 32; i++) mem[i] = 32'h0;
   endtask

   task automatic put_hdr(int e, logic [15:0] tag, logic [15:0] idx,
                          logic [31:0] stad, bit pair_ok);
      logic [31:0] c;
      c = 32'h5A3C_0F11 + 32'(e * 7);
      mem[4*e]   = {tag, idx};
      mem[4*e+1] = stad;
      mem[4*e+2] = c;
      mem[4*e+3] = pair_ok ? ~c : c;
   endtask

   // behavioural expectation from the requirements
   task automatic compute_exp();
      logic [31:0] w0, w1;
      bit valid, pins;
      e_n = 8; e_mode = 3'd3; e_addr = 0; e_err = 1; e_ls = 0; e_st = 0; e_cs = 0;
      for (int e = 0; e < 8; e++) begin
         w0 = mem[4*e];
         w1 = mem[4*e+1];
         valid = (w0[31:16] == 16'hB359) && (mem[4*e+2] == ~mem[4*e+3]) &&
                 (w0[3:1] inside {3'b111, 3'b110, 3'b100, 3'b011});
         if (valid) begin
            e_n = e + 1;
            e_err = 0;
            e_ls = w0[7:4];
            e_st = w0[8];
            e_cs = (w0[11:9] != 3'b101);
            case (w0[3:1])
               3'b111: e_mode = 3'd0;
               3'b110: e_mode = 3'd1;
               3'b100: e_mode = 3'd3;
               default: e_mode = 3'd4;
            endcase
            pins = !w0[0] && !strap_en_n;
            if (pins) e_mode = (strap_mode == 2'b11) ? 3'd0 : (strap_mode == 2'b10) ? 3'd1 :
                               (strap_mode == 2'b01) ? 3'd2 : 3'd3;
            if (e_mode <= 3'd2) begin
               if (w1[1:0] != 2'b00 || w1 < LO || w1 > HI) begin
                  e_err = 1; e_mode = 3'd3; e_addr = 0;
               end else e_addr = w1;
            end else e_addr = 0;
            break;
         end
      end
   endtask

   task automatic compare_cycle(int c, string tag);
      bit exp_rd, exp_done;
      int exp_a;
      exp_rd = 0; exp_a = 0;
      for (int k = 0; k < e_n; k++) begin
         if (c - 7*k >= 1 && c - 7*k <= 4) begin
            exp_rd = 1; exp_a = 4*k + (c - 7*k) - 1;
         end
      end
      check(rd_en === exp_rd, {tag, " R2 read strobe"}, 32'(rd_en), 32'(exp_rd));
      if (exp_rd)
         check(rd_addr === 8'(exp_a), {tag, " R2 read address"}, 32'(rd_addr), 32'(exp_a));
      exp_done = (c >= 7*e_n);
      check(done === exp_done, {tag, " R2 done edge"}, 32'(done), 32'(exp_done));
      if (exp_done) begin
         check(error === e_err, {tag, " error"}, 32'(error), 32'(e_err));
         check(boot_mode === e_mode, {tag, " boot_mode"}, 32'(boot_mode), 32'(e_mode));
         check(start_addr === e_addr, {tag, " start_addr"}, start_addr, e_addr);
         check(lockstep_en === e_ls, {tag, " R5 lockstep"}, 32'(lockstep_en), 32'(e_ls));
         check(selftest_en === e_st, {tag, " R5 selftest"}, 32'(selftest_en), 32'(e_st));
         check(checker_en === e_cs, {tag, " R5 checker"}, 32'(checker_en), 32'(e_cs));
      end
   endtask

   task automatic run_case(string tag);
      int c;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(done === 1'b0 && error === 1'b0 && rd_en === 1'b0, {tag, " R1 in reset"},
            {29'd0, done, error, rd_en}, 32'd0);
      compute_exp();
      rst_n = 1'b1;
      c = 0;
      check(boot_mode === 3'd3 && start_addr === 32'd0 && lockstep_en === 4'd0 &&
            selftest_en === 1'b0 && checker_en === 1'b0 && done === 1'b0 && rd_en === 1'b0,
            {tag, " R1 released"}, 32'(boot_mode), 32'd3);
      for (int i = 0; i < 7*e_n + 20; i++) begin
         @(posedge clk);
         c++;
         @(negedge clk);
         compare_cycle(c, tag);
         if (flip_straps && c == 7*e_n + 3) begin
            strap_en_n = ~strap_en_n;
            strap_mode = ~strap_mode;
         end
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R4 R5 flash start from original 0
      clear_mem(); strap_en_n = 1; strap_mode = 2'b00;
      put_hdr(0, 16'hB359, mk_idx(1, 3'b111, 4'b1010, 1, 3'b000), GA, 1);
      run_case("R4 R5 flash");

      // R3 bad tag on original 0, duplicate 0 alternate boot with checker off
      clear_mem();
      put_hdr(0, 16'hB358, mk_idx(1, 3'b111, 4'b1111, 1, 3'b000), GA, 1);
      put_hdr(1, 16'hB359, mk_idx(1, 3'b110, 4'b0001, 0, 3'b101), GA + 32'h40, 1);
      run_case("R3 R5 tag");

      // R3 broken pair, R4 undefined code, serial loader ignores odd address
      clear_mem();
      put_hdr(0, 16'hB359, mk_idx(1, 3'b111, 4'b0000, 0, 3'b000), GA, 0);
      put_hdr(1, 16'hB359, mk_idx(1, 3'b000, 4'b0000, 0, 3'b000), GA, 1);
      put_hdr(2, 16'hB359, mk_idx(1, 3'b011, 4'b0110, 1, 3'b111), 32'h0000_0003, 1);
      run_case("R3 R4 R7 skip");

      // R6 straps pick alternate boot with serial fallback
      clear_mem(); strap_en_n = 0; strap_mode = 2'b01;
      put_hdr(0, 16'hB359, mk_idx(0, 3'b100, 4'b0011, 0, 3'b000), GA, 1);
      run_case("R6 strap01");

      clear_mem(); strap_en_n = 0; strap_mode = 2'b10;
      put_hdr(0, 16'hB359, mk_idx(0, 3'b011, 4'b0000, 0, 3'b000), GA, 1);
      run_case("R6 strap10");

      clear_mem(); strap_en_n = 0; strap_mode = 2'b00;
      put_hdr(0, 16'hB359, mk_idx(0, 3'b111, 4'b0000, 0, 3'b000), GA, 1);
      run_case("R6 strap00");

      // R6 header bit 0 blocks straps
      clear_mem(); strap_en_n = 0; strap_mode = 2'b11;
      put_hdr(0, 16'hB359, mk_idx(1, 3'b100, 4'b0000, 0, 3'b000), GA, 1);
      run_case("R6 blocked");

      // R6 strap enable high keeps header mode
      clear_mem(); strap_en_n = 1; strap_mode = 2'b11;
      put_hdr(0, 16'hB359, mk_idx(0, 3'b100, 4'b0000, 0, 3'b000), GA, 1);
      run_case("R6 pin high");

      // R7 misaligned flash address
      clear_mem(); strap_en_n = 1;
      put_hdr(0, 16'hB359, mk_idx(1, 3'b111, 4'b0101, 0, 3'b010), GA + 32'd2, 1);
      run_case("R7 misaligned");

      // R7 above and below flash
      clear_mem();
      put_hdr(0, 16'hB359, mk_idx(1, 3'b110, 4'b0000, 1, 3'b000), HI + 32'd4, 1);
      run_case("R7 above");
      clear_mem();
      put_hdr(0, 16'hB359, mk_idx(1, 3'b111, 4'b0000, 0, 3'b000), LO - 32'd4, 1);
      run_case("R7 below");

      // R7 exact bounds accepted
      clear_mem();
      put_hdr(0, 16'hB359, mk_idx(1, 3'b111, 4'b1000, 0, 3'b000), LO, 1);
      run_case("R7 low bound");
      clear_mem();
      put_hdr(0, 16'hB359, mk_idx(1, 3'b110, 4'b0100, 0, 3'b000), HI, 1);
      run_case("R7 high bound");

      // R8 nothing valid, R9 straps toggled after done
      clear_mem(); strap_en_n = 0; strap_mode = 2'b11; flip_straps = 1;
      for (int e = 0; e < 8; e++) put_hdr(e, 16'hB359, mk_idx(0, 3'b111, 4'b1111, 1, 3'b000), GA, 0);
      run_case("R8 R9 none");
      flip_straps = 0;

      // R2 only last duplicate valid
      clear_mem(); strap_en_n = 1;
      put_hdr(7, 16'hB359, mk_idx(1, 3'b111, 4'b1100, 1, 3'b000), GA + 32'h100, 1);
      run_case("R2 last entry");

      // R10 first valid wins, R9 straps changed after done
      clear_mem(); flip_straps = 1; strap_en_n = 1; strap_mode = 2'b00;
      put_hdr(0, 16'hB359, mk_idx(0, 3'b111, 4'b0001, 0, 3'b000), GA, 1);
      put_hdr(1, 16'hB359, mk_idx(1, 3'b110, 4'b1110, 1, 3'b101), GA + 32'h80, 1);
      run_case("R10 R9 first");
      flip_straps = 0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule